// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block drives the configuration load of an SRAM-based programmable device over a passive serial link. A host pulses a start input and then streams configuration bytes through a valid/ready handshake. The last byte is flagged by an end-of-stream strobe. The loader turns on power to the target, holds its configuration-request line low for a fixed interval, and then shifts each byte out on a serial data line against a divided serial clock. After the last byte it sends a run of extra clocks and then reads the target's two status lines.

When the load finishes, a one-cycle done pulse is raised. An error flag and the captured two-bit status code come with it, and both stay readable until the next start. When no load is running, the target's power control follows a separate host input.

Top module: `ps_cfg_loader`

## Requirements
- R1: A start pulse while idle begins a load. busy_o is high from the cycle after start until done_o. tgt_pwr_n_o is low (target powered) in every cycle that busy_o is high.
- R2: tgt_cfg_req_n_o goes low for exactly PULSE_CYC = (CLK_HZ/1000)*PULSE_US/1000 system cycles, once per load. It is high again before the first serial clock rise.
- R3: Bytes are serialized least-significant bit first. Each bit is presented on tgt_sdata_o for exactly one rising edge of tgt_sclk_o, and each byte takes eight rising edges.
- R4: tgt_sdata_o changes only while tgt_sclk_o is low. tgt_sclk_o is low whenever no bit or trailing clock is in progress.
- R5: After the byte that carries the end-of-stream flag, exactly TRAIL_CLKS further rising edges of tgt_sclk_o occur, with tgt_sdata_o at 0 on each.
- R6: After the trailing clocks, stat_o captures the status code: the configuration-done input in bit 1 and the status input in bit 0. done_o pulses for one cycle. err_o is 0 only when the code is 2'b11. err_o and stat_o hold their values until the next accepted start.
- R7: A start pulse while busy_o is high has no effect. The load in progress keeps its single request pulse, its bit stream and its single done pulse.
- R8: While busy_o is low, tgt_pwr_n_o equals the inverse of pwr_ctl_i.
- R9: in_ready_o is high only while the loader waits for the next byte, and never while idle. A byte transfers on a cycle where in_valid_i and in_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (ignored while busy) |
| pwr_ctl_i | input | 1 | Requested target power while idle (1 = on) |
| in_data_i | input | 8 | Configuration byte |
| in_valid_i | input | 1 | Byte on in_data_i is valid |
| in_last_i | input | 1 | Marks the current byte as the last of the stream |
| in_ready_o | output | 1 | Loader accepts a byte this cycle |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse at the end of a load |
| err_o | output | 1 | Last load failed its status check |
| stat_o | output | 2 | Captured code {config-done, status} |
| tgt_pwr_n_o | output | 1 | Target power-down, low = powered |
| tgt_cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| tgt_sdata_o | output | 1 | Serial configuration data |
| tgt_sclk_o | output | 1 | Serial configuration clock |
| tgt_status_i | input | 1 | Target status line, high = healthy |
| tgt_cfg_done_i | input | 1 | Target configuration-done line |

## Verification
Two functions can fall in the same cycle: a fresh start request, and the acceptance of a stream byte in the middle of a load. The bench raises start_i so that it is held through the very clock edge on which a byte is handed over. The case is judged at the target pins. The monitor must still see exactly one request pulse of the exact length, the full least-significant-first bit stream followed by the zero trailer, and one done pulse with the expected status code. Across the four status-line combinations and one to three bytes per stream, the bench also computes every expected bit from the bytes it sent.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_FETCH,
        ST_SHIFT,
        ST_TRAIL,
        ST_CHECK
    } cfg_st_e;

    localparam logic [1:0] STAT_PASS = 2'b11;
endpackage

// File: rtl/ps_cfg_bitclk.sv
// Serial clock generator: one bit slot is DIV system cycles,
// low in the first half and high in the second.
module ps_cfg_bitclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic slot_end_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i) begin
            cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sclk_o     = (cnt_q >= CW'(HALF));
    assign slot_end_o = run_i && (cnt_q == CW'(DIV - 1));

    // R4
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!sclk_o || run_i));
endmodule

// File: rtl/ps_cfg_serializer.sv
// Shift register presenting the LSB; zero fill keeps the line at 0 afterwards.
module ps_cfg_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)       sr_d = data_i;
        else if (shift_i) sr_d = {1'b0, sr_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign bit_o = sr_q[0];
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PULSE_US   = 200,
    parameter int SCLK_DIV   = 4,
    parameter int TRAIL_CLKS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       pwr_ctl_i,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] stat_o,
    output logic       tgt_pwr_n_o,
    output logic       tgt_cfg_req_n_o,
    output logic       tgt_sdata_o,
    output logic       tgt_sclk_o,
    input  logic       tgt_status_i,
    input  logic       tgt_cfg_done_i
);
    localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;
    localparam int PCW       = $clog2(PULSE_CYC + 1);
    localparam int TCW       = $clog2(TRAIL_CLKS + 1);

    typedef struct packed {
        cfg_st_e        st;
        logic [PCW-1:0] pcnt;
        logic [2:0]     bits;
        logic [TCW-1:0] tcnt;
        logic           last;
        logic           busy;
        logic           done;
        logic           err;
        logic [1:0]     stat;
    } regs_t;

    regs_t r_d, r_q;
    logic  run, slot_end, ld, sh;

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        run    = 1'b0;
        ld     = 1'b0;
        sh     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_PULSE;
                    r_d.pcnt = PCW'(PULSE_CYC - 1);
                    r_d.busy = 1'b1;
                    r_d.err  = 1'b0;
                    r_d.stat = '0;
                end
            end
            ST_PULSE: begin
                if (r_q.pcnt == '0) r_d.st = ST_FETCH;
                else                r_d.pcnt = r_q.pcnt - 1'b1;
            end
            ST_FETCH: begin
                if (in_valid_i) begin
                    ld       = 1'b1;
                    r_d.last = in_last_i;
                    r_d.bits = 3'd7;
                    r_d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                run = 1'b1;
                if (slot_end) begin
                    sh = 1'b1;
                    if (r_q.bits == '0) begin
                        r_d.st   = r_q.last ? ST_TRAIL : ST_FETCH;
                        r_d.tcnt = TCW'(TRAIL_CLKS - 1);
                    end else begin
                        r_d.bits = r_q.bits - 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                run = 1'b1;
                if (slot_end) begin
                    if (r_q.tcnt == '0) r_d.st = ST_CHECK;
                    else                r_d.tcnt = r_q.tcnt - 1'b1;
                end
            end
            ST_CHECK: begin
                r_d.stat = {tgt_cfg_done_i, tgt_status_i};
                r_d.err  = ({tgt_cfg_done_i, tgt_status_i} != STAT_PASS);
                r_d.done = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pcnt: '0, bits: '0, tcnt: '0, last: 1'b0,
                     busy: 1'b0, done: 1'b0, err: 1'b0, stat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    ps_cfg_bitclk #(.DIV(SCLK_DIV)) u_bitclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .sclk_o     (tgt_sclk_o),
        .slot_end_o (slot_end)
    );

    ps_cfg_serializer #(.W(8)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .data_i  (in_data_i),
        .shift_i (sh),
        .bit_o   (tgt_sdata_o)
    );

    assign in_ready_o      = (r_q.st == ST_FETCH);
    assign busy_o          = r_q.busy;
    assign done_o          = r_q.done;
    assign err_o           = r_q.err;
    assign stat_o          = r_q.stat;
    assign tgt_cfg_req_n_o = (r_q.st != ST_PULSE);
    assign tgt_pwr_n_o     = r_q.busy ? 1'b0 : ~pwr_ctl_i;

    // R1
    powered_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !tgt_pwr_n_o);
    // R2
    req_within_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_cfg_req_n_o |-> busy_o);
    // R9
    ready_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (tgt_cfg_req_n_o && busy_o));
    // R4
    data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sclk_o && $past(tgt_sclk_o)) |-> $stable(tgt_sdata_o));
    // R6
    done_ends_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy_o) && !busy_o));
    // R8
    idle_power_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tgt_pwr_n_o == !pwr_ctl_i));
endmodule

// File: tb/ps_cfg_loader_bench.sv
module ps_cfg_loader_bench;
    localparam int CLK_HZ     = 100_000;
    localparam int PULSE_US   = 200;
    localparam int SCLK_DIV   = 4;
    localparam int TRAIL_CLKS = 50;
    localparam int PULSE_CYC  = (CLK_HZ / 1000) * PULSE_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, pwr_ctl_i = 1'b0;
    logic [7:0] in_data_i = '0;
    logic in_valid_i = 1'b0, in_last_i = 1'b0;
    logic in_ready_o, busy_o, done_o, err_o;
    logic [1:0] stat_o;
    logic tgt_pwr_n_o, tgt_cfg_req_n_o, tgt_sdata_o, tgt_sclk_o;
    logic tgt_status_i = 1'b0, tgt_cfg_done_i = 1'b0;

    int checks = 0, errors = 0, cycles = 0;

    ps_cfg_loader #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US),
                    .SCLK_DIV(SCLK_DIV), .TRAIL_CLKS(TRAIL_CLKS)) u_ps_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_ctl_i(pwr_ctl_i),
        .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
        .in_ready_o(in_ready_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .stat_o(stat_o), .tgt_pwr_n_o(tgt_pwr_n_o), .tgt_cfg_req_n_o(tgt_cfg_req_n_o),
        .tgt_sdata_o(tgt_sdata_o), .tgt_sclk_o(tgt_sclk_o),
        .tgt_status_i(tgt_status_i), .tgt_cfg_done_i(tgt_cfg_done_i));

    always #10 clk = ~clk;

    // pin monitor, sampled at the falling system edge
    logic got_bits [0:255];
    int   nrise = 0, pulse_len = 0, pulse_cnt = 0, done_cnt = 0;
    int   pwr_bad = 0, req_low_at_rise = 0, sdata_hi_change = 0;
    logic prev_sclk = 1'b0, prev_req = 1'b1, prev_sdata = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrise = 0; pulse_len = 0; pulse_cnt = 0; done_cnt = 0;
        pwr_bad = 0; req_low_at_rise = 0; sdata_hi_change = 0;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (tgt_sclk_o && !prev_sclk) begin
                if (nrise < 256) got_bits[nrise] = tgt_sdata_o;
                nrise++;
                if (!tgt_cfg_req_n_o) req_low_at_rise++;
            end
            if (tgt_sclk_o && prev_sclk && tgt_sdata_o != prev_sdata) sdata_hi_change++;
            if (!tgt_cfg_req_n_o) pulse_len++;
            if (!tgt_cfg_req_n_o && prev_req) pulse_cnt++;
            if (done_o) done_cnt++;
            if (busy_o && tgt_pwr_n_o) pwr_bad++;
        end
        prev_sclk = tgt_sclk_o; prev_req = tgt_cfg_req_n_o; prev_sdata = tgt_sdata_o;
        if (cycles > 150_000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150_000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_load(input int nb, input logic [1:0] code, input int seed, input bit poke);
        logic [7:0] bytes [0:3];
        int bad_bits, guard;
        tgt_cfg_done_i = code[1];
        tgt_status_i   = code[0];
        for (int i = 0; i < nb; i++) bytes[i] = 8'((seed * 37 + i * 91 + 5) & 255);
        clear_mon();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(busy_o == 1'b1, "R1 busy", int'(busy_o), 1);
        check(in_ready_o == 1'b0, "R9 ready during pulse", int'(in_ready_o), 0);
        for (int i = 0; i < nb; i++) begin
            in_data_i = bytes[i]; in_valid_i = 1'b1; in_last_i = (i == nb - 1);
            guard = 0;
            while (!in_ready_o && guard < 2000) begin @(negedge clk); guard++; end
            // R7: start held across the edge that accepts a byte
            if (poke && i == nb - 1) start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
        end
        guard = 0;
        while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
        check(done_o == 1'b1, "R6 done seen", int'(done_o), 1);
        check(err_o == (code != 2'b11), "R6 err", int'(err_o), int'(code != 2'b11));
        check(stat_o == code, "R6 stat", int'(stat_o), int'(code));
        check(busy_o == 1'b0, "R1 busy cleared", int'(busy_o), 0);
        bad_bits = 0;
        for (int k = 0; k < nb * 8; k++)
            if (k < 256 && got_bits[k] !== bytes[k / 8][k % 8]) bad_bits++;
        for (int k = nb * 8; k < nb * 8 + TRAIL_CLKS; k++)
            if (k < 256 && got_bits[k] !== 1'b0) bad_bits++;
        check(nrise == nb * 8 + TRAIL_CLKS, "R3 R5 rise count", nrise, nb * 8 + TRAIL_CLKS);
        check(bad_bits == 0, "R3 R5 bit stream", bad_bits, 0);
        check(sdata_hi_change == 0, "R4 data while sclk high", sdata_hi_change, 0);
        check(pulse_len == PULSE_CYC, "R2 pulse length", pulse_len, PULSE_CYC);
        check(pulse_cnt == 1, "R2 R7 pulse count", pulse_cnt, 1);
        check(req_low_at_rise == 0, "R2 released before data", req_low_at_rise, 0);
        check(pwr_bad == 0, "R1 power during load", pwr_bad, 0);
        repeat (6) @(negedge clk);
        check(done_cnt == 1, "R6 R7 single done", done_cnt, 1);
        check(done_o == 1'b0 && busy_o == 1'b0, "R7 no restart", int'(busy_o), 0);
        check(err_o == (code != 2'b11) && stat_o == code, "R6 hold", int'(stat_o), int'(code));
        check(tgt_sclk_o == 1'b0 && in_ready_o == 1'b0, "R4 R9 idle lines",
              int'(tgt_sclk_o) + int'(in_ready_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && err_o == 0, "R1 reset flags", int'(busy_o), 0);
        check(tgt_cfg_req_n_o == 1 && tgt_sclk_o == 0 && in_ready_o == 0,
              "R9 reset lines", int'(tgt_cfg_req_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        pwr_ctl_i = 1'b1; @(negedge clk);
        check(tgt_pwr_n_o == 1'b0, "R8 idle power on", int'(tgt_pwr_n_o), 0);
        pwr_ctl_i = 1'b0; @(negedge clk);
        check(tgt_pwr_n_o == 1'b1, "R8 idle power off", int'(tgt_pwr_n_o), 1);
        for (int c = 0; c < 4; c++)
            for (int nb = 1; nb <= 3; nb++)
                run_load(nb, 2'(c), c * 3 + nb, (c == 2 && nb == 3));
        run_load(2, 2'b11, 99, 1'b1);
        pwr_ctl_i = 1'b1; @(negedge clk);
        check(tgt_pwr_n_o == 1'b0, "R8 power after load", int'(tgt_pwr_n_o), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule